// File: doc/BRIEF.md
# Random Word Generator Control Block

This block is the register-side controller of a random number peripheral that sits on a simple memory-mapped bus. Once software sets its run bit, it samples one bit per clock from an external entropy input. After every 84 enabled clock cycles it freezes the most recent 32 samples into a read-only result register. It then raises a word-ready flag, and when enabled it requests an interrupt and pulses an event line.

Software configures the block through six word addresses. These are a run control, an event-output configuration that can only change while stopped, a pair of write-one-to-set and write-one-to-clear interrupt mask addresses, a word-ready flag, and the result register. Reading the result register, or writing 1 to the flag, acknowledges the word. Stopping the block restarts the cadence from zero without losing the last result.

Top module: `rng_ctrl`

## Requirements
- R1: Address 0 bit 0 is the run bit. Writing 1 starts word generation and writing 0 stops it. The bit reads back at address 0 bit 0.
- R2: After the clock edge that writes run = 1, the first word is latched on the 84th following rising edge, and each later word 84 edges after the one before. No word is latched earlier.
- R3: A latched word holds the last 32 entropy samples, one taken per enabled rising edge. The sample from the latching edge sits in bit 0 and the oldest sample in bit 31. It reads at address 5.
- R4: Address 1 bit 0 enables the event output. A write to it is ignored while the run bit is 1 and takes effect while the run bit is 0. It reads back at address 1 bit 0.
- R5: Writing 1 to bit 0 of address 2 sets the interrupt mask bit, and writing 1 to bit 0 of address 3 clears it. Writing 0 to either address changes nothing. Reading either address returns the mask in bit 0.
- R6: The interrupt output is high exactly when the word-ready flag and the mask bit are both 1. It falls when either one is cleared.
- R7: The word-ready flag, read at address 4 bit 0, sets when a word is latched. It clears on a write of 1 to address 4 bit 0 or on a read of address 5. A write of 0 to address 4 leaves it unchanged.
- R8: When a word is latched on the same edge as a flag clear, whether by a write or by a result read, the flag ends up set.
- R9: With the event enable at 1, the event output is high for exactly one cycle, the cycle after each latching edge. With the enable at 0 it stays low.
- R10: While stopped, no word is latched, the cycle counter and the sample collector return to zero, and the result register keeps its value. Restarting therefore takes a full 84 edges to produce a word.
- R11: An active-low reset clears the run bit, event enable, mask, flag, result register and event output to zero.
- R12: Writes to address 5 are ignored, and addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel (side effects on address 5) |
| bus_addr | input | 3 | Word address |
| bus_wbit | input | 1 | Bit 0 of the write data; no register stores any higher bit |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| noise_i | input | 1 | Entropy sample input |
| irq_o | output | 1 | Interrupt request |
| evt_o | output | 1 | Word event pulse |

## Verification
The bench probes the exact edge on which a word lands. An off-by-one counter would show the flag one cycle early or late, or would latch the wrong 32-bit window of the entropy history. It drives flag clears, both by write and by result read, into that same latching edge. A design that lets the clear win would lose the word-ready flag. It tries to change the event enable while running, which a design without the lock would accept. It also stops the block partway through a period: a counter that is not reset would deliver a word early after restart, and a result register that is not held would lose its value.

// File: rtl/rng_pkg.sv
package rng_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_EVCFG = 3'd1,
    RA_IESET = 3'd2,
    RA_IECLR = 3'd3,
    RA_FLAGS = 3'd4,
    RA_DATA  = 3'd5
  } rng_addr_e;

  typedef struct packed {
    logic ctrl_wr;
    logic evcfg_wr;
    logic ieset_wr;
    logic ieclr_wr;
    logic flags_wr;
    logic data_rd;
  } rng_acc_t;

endpackage

// File: rtl/rng_bus_dec.sv
module rng_bus_dec
  import rng_pkg::*;
(
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  output rng_acc_t          acc_o
);

  logic wr_hit;
  logic rd_hit;

  assign wr_hit = sel_i & wr_i;
  assign rd_hit = sel_i & rd_i;

  always_comb begin
    acc_o          = '0;
    acc_o.ctrl_wr  = wr_hit & (addr_i == RA_CTRL);
    acc_o.evcfg_wr = wr_hit & (addr_i == RA_EVCFG);
    acc_o.ieset_wr = wr_hit & (addr_i == RA_IESET);
    acc_o.ieclr_wr = wr_hit & (addr_i == RA_IECLR);
    acc_o.flags_wr = wr_hit & (addr_i == RA_FLAGS);
    acc_o.data_rd  = rd_hit & (addr_i == RA_DATA);
  end

endmodule

// File: rtl/rng_collector.sv
module rng_collector #(
  parameter int DATA_W = 32,
  parameter int PERIOD = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              noise_i,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_o
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] shifted;
  logic              at_last;

  generate
    if (DATA_W == 1) begin : g_single
      assign shifted = noise_i;
    end else begin : g_multi
      assign shifted = {shreg_q[DATA_W-2:0], noise_i};
    end
  endgenerate

  assign at_last      = (cnt_q == LAST);
  assign word_valid_o = run_i & at_last;
  assign word_o       = shifted;

  always_comb begin
    if (!run_i) begin
      cnt_d   = '0;
      shreg_d = '0;
    end else begin
      cnt_d   = at_last ? '0 : cnt_q + 1'b1;
      shreg_d = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
    end
  end

endmodule

// File: rtl/rng_regs.sv
module rng_regs
  import rng_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rng_acc_t          acc_i,
  input  logic              wbit_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic              ev_en_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              evt_o
);

  logic              run_q, run_d;
  logic              ev_en_q, ev_en_d;
  logic              ie_q, ie_d;
  logic              flag_q, flag_d;
  logic              evt_q, evt_d;
  logic [DATA_W-1:0] data_q;
  logic              flag_clr;

  // next-state logic
  always_comb begin
    run_d = acc_i.ctrl_wr ? wbit_i : run_q;

    ev_en_d = ev_en_q;
    if (acc_i.evcfg_wr && !run_q)
      ev_en_d = wbit_i;

    ie_d = ie_q;
    if (acc_i.ieset_wr && wbit_i)
      ie_d = 1'b1;
    else if (acc_i.ieclr_wr && wbit_i)
      ie_d = 1'b0;

    flag_clr = (acc_i.flags_wr & wbit_i) | acc_i.data_rd;
    if (word_valid_i)
      flag_d = 1'b1;
    else if (flag_clr)
      flag_d = 1'b0;
    else
      flag_d = flag_q;

    evt_d = word_valid_i & ev_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ev_en_q <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      ev_en_q <= ev_en_d;
      ie_q    <= ie_d;
      flag_q  <= flag_d;
      evt_q   <= evt_d;
    end
  end

  // result register, clock-enabled by a new word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (word_valid_i)
      data_q <= word_i;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL:  rdata_o[0] = run_q;
      RA_EVCFG: rdata_o[0] = ev_en_q;
      RA_IESET: rdata_o[0] = ie_q;
      RA_IECLR: rdata_o[0] = ie_q;
      RA_FLAGS: rdata_o[0] = flag_q;
      RA_DATA:  rdata_o    = data_q;
      default:  rdata_o    = '0;
    endcase
  end

  assign run_o   = run_q;
  assign ev_en_o = ev_en_q;
  assign ie_o    = ie_q;
  assign flag_o  = flag_q;
  assign data_o  = data_q;
  assign irq_o   = flag_q & ie_q;
  assign evt_o   = evt_q;

endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PERIOD = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wbit,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              noise_i,
  output logic              irq_o,
  output logic              evt_o
);

  rng_acc_t          acc;
  logic              ctrl_en;
  logic              ev_en;
  logic              rdy_ie;
  logic              rdy_flag;
  logic              word_valid;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] data_word;

  rng_bus_dec u_dec (
    .sel_i  (bus_sel),
    .wr_i   (bus_wr),
    .rd_i   (bus_rd),
    .addr_i (bus_addr),
    .acc_o  (acc)
  );

  rng_collector #(
    .DATA_W (DATA_W),
    .PERIOD (PERIOD)
  ) u_col (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ctrl_en),
    .noise_i      (noise_i),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  rng_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_i        (acc),
    .wbit_i       (bus_wbit),
    .addr_i       (bus_addr),
    .word_valid_i (word_valid),
    .word_i       (word),
    .rdata_o      (bus_rdata),
    .run_o        (ctrl_en),
    .ev_en_o      (ev_en),
    .ie_o         (rdy_ie),
    .flag_o       (rdy_flag),
    .data_o       (data_word),
    .irq_o        (irq_o),
    .evt_o        (evt_o)
  );

endmodule

// File: rtl/rng_ctrl_sva.sv
module rng_ctrl_sva #(
  parameter int DATA_W = 32,
  parameter int PERIOD = 84
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              word_valid,
  input logic              ev_en,
  input logic              flag,
  input logic              ie,
  input logic              irq,
  input logic              evt,
  input logic [DATA_W-1:0] data
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LASTC = CW'(PERIOD - 1);

  logic [CW-1:0] chk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chk_cnt <= '0;
    else if (!run)
      chk_cnt <= '0;
    else if (chk_cnt == LASTC)
      chk_cnt <= '0;
    else
      chk_cnt <= chk_cnt + 1'b1;
  end

  p_word_on_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (run && chk_cnt == LASTC));

  p_word_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && chk_cnt == LASTC) |-> word_valid);

  p_evcfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ev_en));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> flag);

  p_evt_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(word_valid));

  p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(data));

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !word_valid);

endmodule

bind rng_ctrl rng_ctrl_sva #(
  .DATA_W (DATA_W),
  .PERIOD (PERIOD)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (ctrl_en),
  .word_valid (word_valid),
  .ev_en      (ev_en),
  .flag       (rdy_flag),
  .ie         (rdy_ie),
  .irq        (irq_o),
  .evt        (evt_o),
  .data       (data_word)
);

// File: tb/rng_ctrl_test.sv
module rng_ctrl_test;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_EVCFG = 3'd1;
  localparam logic [2:0] A_IESET = 3'd2;
  localparam logic [2:0] A_IECLR = 3'd3;
  localparam logic [2:0] A_FLAGS = 3'd4;
  localparam logic [2:0] A_DATA  = 3'd5;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic        bus_rd;
  logic [2:0]  bus_addr;
  logic        bus_wbit;
  logic [31:0] bus_rdata;
  logic        noise_i;
  logic        irq_o;
  logic        evt_o;

  logic [31:0] lfsr;
  logic [31:0] hist;
  int          checks;
  int          errors;

  rng_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wbit  (bus_wbit),
    .bus_rdata (bus_rdata),
    .noise_i   (noise_i),
    .irq_o     (irq_o),
    .evt_o     (evt_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // entropy stand-in: Galois LFSR, stepped away from the sampling edge
  initial lfsr = 32'hACE1_2468;
  always @(negedge clk)
    lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? 32'h8020_0003 : 32'h0);
  assign noise_i = lfsr[0];

  // history of every sampled entropy bit, newest in bit 0
  initial hist = '0;
  always @(posedge clk) hist <= {hist[30:0], noise_i};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus tasks: called just after a falling edge, consume one rising edge
  task automatic wr(input logic [2:0] a, input logic b);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wbit = b;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wbit = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // stop, clear flag, start; returns one edge after the first word lands
  task automatic start_word(input logic ev_exp, output logic [31:0] exp);
    logic [31:0] v;
    wr(A_CTRL, 1'b0);
    wr(A_FLAGS, 1'b1);
    wr(A_CTRL, 1'b1);
    repeat (83) @(negedge clk);
    rd(A_FLAGS, v);
    chk("R2 no word before 84th edge", v, 32'd0);
    exp = hist;
    chk("R9 event pulse after latch", {31'd0, evt_o}, {31'd0, ev_exp});
    rd(A_FLAGS, v);
    chk("R2 word on 84th edge", v, 32'd1);
    chk("R9 event lasts one cycle", {31'd0, evt_o}, 32'd0);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R11 register zero after reset", v, 32'd0);
    end
    chk("R11 irq low after reset", {31'd0, irq_o}, 32'd0);
    chk("R11 event low after reset", {31'd0, evt_o}, 32'd0);
  endtask

  task automatic t_cadence;
    logic [31:0] v, e1, e2;
    wr(A_CTRL, 1'b0);
    wr(A_EVCFG, 1'b1);
    start_word(1'b1, e1);
    rd(A_DATA, v);
    chk("R3 first word content", v, e1);
    repeat (81) @(negedge clk);
    rd(A_DATA, v);
    chk("R2 second word not early", v, e1);
    e2 = hist;
    chk("R9 second event pulse", {31'd0, evt_o}, 32'd1);
    rd(A_DATA, v);
    chk("R3 second word content", v, e2);
  endtask

  task automatic t_evcfg_lock;
    logic [31:0] v, e;
    wr(A_CTRL, 1'b0);
    wr(A_EVCFG, 1'b1);
    wr(A_CTRL, 1'b1);
    rd(A_CTRL, v);
    chk("R1 run bit reads 1", v, 32'd1);
    wr(A_EVCFG, 1'b0);
    rd(A_EVCFG, v);
    chk("R4 event enable locked while running", v, 32'd1);
    wr(A_CTRL, 1'b0);
    wr(A_EVCFG, 1'b0);
    rd(A_EVCFG, v);
    chk("R4 event enable writable when stopped", v, 32'd0);
    start_word(1'b0, e);
    rd(A_DATA, v);
    chk("R3 word content with events off", v, e);
  endtask

  task automatic t_irq;
    logic [31:0] v, e;
    wr(A_IESET, 1'b1);
    rd(A_IESET, v);
    chk("R5 mask set read at set address", v, 32'd1);
    rd(A_IECLR, v);
    chk("R5 mask read at clear address", v, 32'd1);
    start_word(1'b0, e);
    chk("R6 irq with flag and mask", {31'd0, irq_o}, 32'd1);
    wr(A_IECLR, 1'b0);
    chk("R5 zero to clear address ignored", {31'd0, irq_o}, 32'd1);
    wr(A_IESET, 1'b0);
    chk("R5 zero to set address ignored", {31'd0, irq_o}, 32'd1);
    wr(A_IECLR, 1'b1);
    chk("R6 irq drops when masked", {31'd0, irq_o}, 32'd0);
    rd(A_FLAGS, v);
    chk("R7 flag kept when masked", v, 32'd1);
    wr(A_IESET, 1'b1);
    chk("R6 irq returns when unmasked", {31'd0, irq_o}, 32'd1);
    wr(A_FLAGS, 1'b0);
    chk("R7 zero to flag ignored", {31'd0, irq_o}, 32'd1);
    wr(A_FLAGS, 1'b1);
    chk("R7 write one clears flag", {31'd0, irq_o}, 32'd0);
    start_word(1'b0, e);
    chk("R6 irq on new word", {31'd0, irq_o}, 32'd1);
    rd(A_DATA, v);
    chk("R3 word content", v, e);
    chk("R7 result read clears flag", {31'd0, irq_o}, 32'd0);
    wr(A_IECLR, 1'b1);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(A_CTRL, 1'b0);
    wr(A_FLAGS, 1'b1);
    wr(A_CTRL, 1'b1);
    repeat (83) @(negedge clk);
    wr(A_FLAGS, 1'b1);
    rd(A_FLAGS, v);
    chk("R8 new word beats write clear", v, 32'd1);
    repeat (82) @(negedge clk);
    rd(A_DATA, v);
    rd(A_FLAGS, v);
    chk("R8 new word beats read clear", v, 32'd1);
  endtask

  task automatic t_disable;
    logic [31:0] v, e, e2;
    start_word(1'b0, e);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 1'b0);
    wr(A_FLAGS, 1'b1);
    repeat (200) @(negedge clk);
    rd(A_FLAGS, v);
    chk("R10 no word while stopped", v, 32'd0);
    rd(A_CTRL, v);
    chk("R1 run bit reads 0", v, 32'd0);
    rd(A_DATA, v);
    chk("R10 result held while stopped", v, e);
    start_word(1'b0, e2);
    rd(A_DATA, v);
    chk("R10 full period after restart", v, e2);
  endtask

  task automatic t_map;
    logic [31:0] v0, v;
    wr(A_CTRL, 1'b0);
    rd(A_DATA, v0);
    wr(A_DATA, 1'b1);
    wr(A_DATA, 1'b0);
    rd(A_DATA, v);
    chk("R12 result register read-only", v, v0);
    rd(3'd6, v);
    chk("R12 address 6 reads zero", v, 32'd0);
    rd(3'd7, v);
    chk("R12 address 7 reads zero", v, 32'd0);
  endtask

  task automatic t_reset_mid;
    wr(A_IESET, 1'b1);
    wr(A_EVCFG, 1'b1);
    wr(A_CTRL, 1'b1);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wbit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_cadence();
    t_evcfg_lock();
    t_irq();
    t_priority();
    t_disable();
    t_map();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule